// File: doc/BRIEF.md
# Shared cache maintenance command queue

This block is the register front-end through which several CPUs post cache maintenance commands into one common queue. Each command has an operation code, a scope (an address range or the whole cache), a start address and a byte count. A CPU builds a command in a set of shared staging registers and commits it by reading its own registration-status register. The first CPU that writes the mode register owns the staging registers until that commit read. While one CPU owns them, staging writes from any other CPU are refused and flagged to that CPU.

Accepted commands enter a FIFO. A model engine executes them one at a time, and each one occupies the engine for a fixed number of cycles. The start of each command is presented on a small operation port, which stands in for the real tag and data array sequencer. Every CPU has its own view of the queue: a busy bit, a completion flag and an error flag, so it sees only the outcome of its own commands. A sync primitive makes a read-back stall until all queued work has drained. A second primitive pulses a prefetch-buffer flush strobe.

Top module: `cmq_frontend`

## Requirements
- R1: After reset, req_ready_o is high and every register reads 0 for every CPU: registration status at 0x25C, queue status at 0x260 and the primitive register at 0x244.
- R2: The mode register is at 0x248. Bits [3:0] hold the operation (0 invalidate, 1 clean, 2 flush), bit 15 requests a completion notification, and bits [18:17] hold the scope (0 = range, 1 = whole cache). The start address is at 0x24C and the byte count at 0x250. A committed command appears on op_code_o, op_all_o, op_addr_o, op_size_o and op_cpu_o with a one-cycle op_start_o pulse.
- R3: The first CPU to write the mode register owns the staging registers. Writes from any other CPU to mode, address or size are refused, leave the staged values unchanged and set that CPU's refusal flag. A write to address or size while no CPU owns the registers is also refused.
- R4: A read of 0x25C returns bit 1 = queue full and bit 0 = refusal flag. When the owner reads it, the command is committed (pushed, unless the queue is full, in which case it is dropped and bit 1 is set) and ownership is released. Every read of 0x25C clears the reader's refusal flag.
- R5: The queue holds DEPTH commands and releases them in arrival order. Commands run one at a time: op_start_o pulses for one cycle, and consecutive starts of back-to-back queued commands are exactly LAT+1 cycles apart.
- R6: For a whole-cache command, op_addr_o and op_size_o are 0, whatever the staged address and size were.
- R7: 0x260 reads per CPU as bit 0 = busy (any of that CPU's commands is queued or running), bit 2 = done (set when one of its notify commands retires) and bit 1 = error (set when a 0x25C read by it returns nonzero). Writing 1 to bit 2 or bit 1 clears that bit. No CPU's bits move for another CPU's commands.
- R8: Writing 0x8 to 0x244 arms a sync. A read of 0x244 while the sync is armed holds req_ready_o low until the queue is empty and the engine is idle, then returns 0x8 and disarms the sync. A read while no sync is armed returns 0 without stalling.
- R9: Writing 0x9 to 0x244 raises pf_flush_o for exactly one cycle after the write. Any other value written there, apart from 0x8, has no effect.
- R10: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access request |
| req_ready_o | output | 1 | Access accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Register byte offset |
| req_wdata_i | input | 32 | Write data |
| req_cpu_i | input | CPU_W | Identity of the requesting CPU |
| req_rdata_o | output | 32 | Read data, valid in the accepting cycle |
| op_start_o | output | 1 | One-cycle pulse when a command starts executing |
| op_cpu_o | output | CPU_W | CPU that submitted the running command |
| op_code_o | output | 4 | Operation code of the running command |
| op_all_o | output | 1 | Running command covers the whole cache |
| op_addr_o | output | 32 | Start address of the running command |
| op_size_o | output | 32 | Byte count of the running command |
| pf_flush_o | output | 1 | Prefetch buffer flush strobe |

## Verification
A lost or wrongly held ownership register shows up on the very next staging access: a CPU that should be refused gets 0 from 0x25C, or a legal owner has its fields missing from the next op_start_o. A per-CPU outstanding count that drifts leaves bit 0 of 0x260 stuck high or clears it early, and a poll of that register reveals this within LAT+1 cycles of retirement. A FIFO pointer fault reorders commands or wrongly reports the queue full, which the bench catches by comparing every started command and its start cycle against a list it computes itself.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
  localparam logic [11:0] OFF_PRIM  = 12'h244;
  localparam logic [11:0] OFF_MODE  = 12'h248;
  localparam logic [11:0] OFF_ADDR  = 12'h24C;
  localparam logic [11:0] OFF_SIZE  = 12'h250;
  localparam logic [11:0] OFF_RSTAT = 12'h25C;
  localparam logic [11:0] OFF_QSTAT = 12'h260;

  localparam logic [31:0] PRIM_SYNC = 32'h8;
  localparam logic [31:0] PRIM_PFL  = 32'h9;

  typedef struct packed {
    logic [3:0]  code;
    logic        all;
    logic        notify;
    logic [31:0] addr;
    logic [31:0] size;
  } cmd_t;
endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [W-1:0]                 din_i,
  output logic [W-1:0]                 dout_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      if (push_i && !pop_i)      cnt <= cnt + 1'b1;
      else if (pop_i && !push_i) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  assign dout_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign cnt_o   = cnt;
endmodule

// File: rtl/cmq_engine.sv
module cmq_engine #(
  parameter int unsigned W   = 8,
  parameter int unsigned LAT = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         avail_i,
  input  logic [W-1:0] cmd_i,
  output logic         pop_o,
  output logic         busy_o,
  output logic         start_o,
  output logic         ret_o,
  output logic [W-1:0] cmd_o
);
  localparam int unsigned TW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy;
  logic [TW-1:0] tmr;

  assign pop_o  = !busy && avail_i;
  assign ret_o  = busy && (tmr == '0);
  assign busy_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy    <= 1'b0;
      tmr     <= '0;
      start_o <= 1'b0;
      cmd_o   <= '0;
    end else begin
      start_o <= pop_o;
      if (pop_o) begin
        busy  <= 1'b1;
        tmr   <= TW'(LAT-1);
        cmd_o <= cmd_i;
      end else if (busy) begin
        if (tmr == '0) busy <= 1'b0;
        else           tmr  <= tmr - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmq_cpu_status.sv
module cmq_cpu_status #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic retire_i,
  input  logic notify_i,
  input  logic fail_i,
  input  logic ovr_set_i,
  input  logic ovr_clr_i,
  input  logic clr_done_i,
  input  logic clr_err_i,
  output logic done_o,
  output logic err_o,
  output logic busy_o,
  output logic ovr_o
);
  localparam int unsigned CW = $clog2(DEPTH+2);

  logic [CW-1:0] outst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (push_i && !retire_i)      outst <= outst + 1'b1;
      else if (retire_i && !push_i) outst <= outst - 1'b1;
      // a new event wins over a clear in the same cycle
      if (retire_i && notify_i) done_o <= 1'b1;
      else if (clr_done_i)      done_o <= 1'b0;
      if (fail_i)         err_o <= 1'b1;
      else if (clr_err_i) err_o <= 1'b0;
      if (ovr_set_i)      ovr_o <= 1'b1;
      else if (ovr_clr_i) ovr_o <= 1'b0;
    end
  end

  assign busy_o = (outst != '0);
endmodule

// File: rtl/cmq_frontend.sv
module cmq_frontend
  import cmq_pkg::*;
#(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LAT   = 4,
  localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [11:0]      req_addr_i,
  input  logic [31:0]      req_wdata_i,
  input  logic [CPU_W-1:0] req_cpu_i,
  output logic [31:0]      req_rdata_o,
  output logic             op_start_o,
  output logic [CPU_W-1:0] op_cpu_o,
  output logic [3:0]       op_code_o,
  output logic             op_all_o,
  output logic [31:0]      op_addr_o,
  output logic [31:0]      op_size_o,
  output logic             pf_flush_o
);
  localparam int unsigned CMD_W = $bits(cmd_t);
  localparam int unsigned ENT_W = CMD_W + CPU_W;
  localparam int unsigned FCW   = $clog2(DEPTH+1);

  // access decode
  logic acc, wr_acc, rd_acc;
  logic hit_mode, hit_addr, hit_size, hit_rstat, hit_qstat, hit_prim;
  assign acc       = req_valid_i && req_ready_o;
  assign wr_acc    = acc && req_write_i;
  assign rd_acc    = acc && !req_write_i;
  assign hit_mode  = (req_addr_i == OFF_MODE);
  assign hit_addr  = (req_addr_i == OFF_ADDR);
  assign hit_size  = (req_addr_i == OFF_SIZE);
  assign hit_rstat = (req_addr_i == OFF_RSTAT);
  assign hit_qstat = (req_addr_i == OFF_QSTAT);
  assign hit_prim  = (req_addr_i == OFF_PRIM);

  // access right on the staging registers
  logic             own_v;
  logic [CPU_W-1:0] own_id;
  logic             is_owner;
  assign is_owner = own_v && (own_id == req_cpu_i);

  logic mode_ok, stage_ok, refuse, rstat_rd, commit;
  assign mode_ok  = wr_acc && hit_mode && (!own_v || is_owner);
  assign stage_ok = wr_acc && (hit_addr || hit_size) && is_owner;
  assign refuse   = wr_acc && ((hit_mode && own_v && !is_owner) ||
                               ((hit_addr || hit_size) && !is_owner));
  assign rstat_rd = rd_acc && hit_rstat;
  assign commit   = rstat_rd && is_owner;

  // staging registers
  logic [3:0]  st_code;
  logic        st_all, st_notify;
  logic [31:0] st_addr, st_size;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_v     <= 1'b0;
      own_id    <= '0;
      st_code   <= '0;
      st_all    <= 1'b0;
      st_notify <= 1'b0;
      st_addr   <= '0;
      st_size   <= '0;
    end else begin
      if (mode_ok) begin
        own_v     <= 1'b1;
        own_id    <= req_cpu_i;
        st_code   <= req_wdata_i[3:0];
        st_notify <= req_wdata_i[15];
        st_all    <= (req_wdata_i[18:17] == 2'd1);
      end else if (commit) begin
        own_v <= 1'b0;
      end
      if (stage_ok && hit_addr) st_addr <= req_wdata_i;
      if (stage_ok && hit_size) st_size <= req_wdata_i;
    end
  end

  // queue and engine
  logic             q_full, q_empty, q_push, q_pop;
  logic [FCW-1:0]   fifo_cnt;
  logic [ENT_W-1:0] q_din, q_dout, eng_ent;
  cmd_t             new_cmd, cur_cmd;
  logic [CPU_W-1:0] cur_cpu;
  logic             eng_busy, eng_start, eng_ret;

  assign q_push = commit && !q_full;

  always_comb begin
    new_cmd.code   = st_code;
    new_cmd.all    = st_all;
    new_cmd.notify = st_notify;
    new_cmd.addr   = st_all ? 32'h0 : st_addr;
    new_cmd.size   = st_all ? 32'h0 : st_size;
  end
  assign q_din = {req_cpu_i, new_cmd};

  cmq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (q_push),
    .pop_i  (q_pop),
    .din_i  (q_din),
    .dout_o (q_dout),
    .empty_o(q_empty),
    .full_o (q_full),
    .cnt_o  (fifo_cnt)
  );

  cmq_engine #(.W(ENT_W), .LAT(LAT)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .avail_i(!q_empty),
    .cmd_i  (q_dout),
    .pop_o  (q_pop),
    .busy_o (eng_busy),
    .start_o(eng_start),
    .ret_o  (eng_ret),
    .cmd_o  (eng_ent)
  );

  assign {cur_cpu, cur_cmd} = eng_ent;
  assign op_start_o = eng_start;
  assign op_cpu_o   = cur_cpu;
  assign op_code_o  = cur_cmd.code;
  assign op_all_o   = cur_cmd.all;
  assign op_addr_o  = cur_cmd.addr;
  assign op_size_o  = cur_cmd.size;

  // per-CPU status
  logic [NCPU-1:0] done_v, err_v, busy_v, ovr_v;
  logic            fail;
  logic            sel_ovr;
  assign sel_ovr = ovr_v[req_cpu_i];
  assign fail    = rstat_rd && (sel_ovr || (commit && q_full));

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic me;
    assign me = (req_cpu_i == CPU_W'(i));
    cmq_cpu_status #(.DEPTH(DEPTH)) u_st (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (q_push && me),
      .retire_i  (eng_ret && (cur_cpu == CPU_W'(i))),
      .notify_i  (cur_cmd.notify),
      .fail_i    (fail && me),
      .ovr_set_i (refuse && me),
      .ovr_clr_i (rstat_rd && me),
      .clr_done_i(wr_acc && hit_qstat && me && req_wdata_i[2]),
      .clr_err_i (wr_acc && hit_qstat && me && req_wdata_i[1]),
      .done_o    (done_v[i]),
      .err_o     (err_v[i]),
      .busy_o    (busy_v[i]),
      .ovr_o     (ovr_v[i])
    );
  end

  // primitives: sync and prefetch flush
  logic sync_pend, drain_wait;
  assign drain_wait  = !q_empty || eng_busy;
  assign req_ready_o = !(req_valid_i && !req_write_i && hit_prim && sync_pend && drain_wait);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_pend  <= 1'b0;
      pf_flush_o <= 1'b0;
    end else begin
      pf_flush_o <= wr_acc && hit_prim && (req_wdata_i == PRIM_PFL);
      if (wr_acc && hit_prim && (req_wdata_i == PRIM_SYNC)) sync_pend <= 1'b1;
      else if (rd_acc && hit_prim)                          sync_pend <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    req_rdata_o = '0;
    if (rd_acc) begin
      if (hit_rstat)      req_rdata_o = {30'h0, commit && q_full, sel_ovr};
      else if (hit_qstat) req_rdata_o = {29'h0, done_v[req_cpu_i], err_v[req_cpu_i], busy_v[req_cpu_i]};
      else if (hit_prim)  req_rdata_o = sync_pend ? PRIM_SYNC : 32'h0;
    end
  end
endmodule

// File: rtl/cmq_checker.sv
module cmq_checker
  import cmq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned FCW   = 3,
  parameter int unsigned CPU_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_write_i,
  input logic [11:0]      req_addr_i,
  input logic [31:0]      req_wdata_i,
  input logic             op_start_o,
  input logic             op_all_o,
  input logic [31:0]      op_addr_o,
  input logic [31:0]      op_size_o,
  input logic             pf_flush_o,
  input logic [FCW-1:0]   fifo_cnt,
  input logic             eng_busy,
  input logic             own_v,
  input logic [CPU_W-1:0] own_id,
  input logic             sync_pend
);
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= FCW'(DEPTH));

  p_single_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |=> !op_start_o);

  p_all_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_start_o && op_all_o) |-> (op_addr_o == 32'h0 && op_size_o == 32'h0));

  p_pf_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_flush_o |-> $past(req_valid_i && req_ready_o && req_write_i &&
                         req_addr_i == OFF_PRIM && req_wdata_i == PRIM_PFL));

  p_owner_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_v && $past(own_v)) |-> (own_id == $past(own_id)));

  p_stall_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (sync_pend && (fifo_cnt != '0 || eng_busy)));
endmodule

bind cmq_frontend cmq_checker #(.DEPTH(DEPTH), .FCW(FCW), .CPU_W(CPU_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .op_start_o (op_start_o),
  .op_all_o   (op_all_o),
  .op_addr_o  (op_addr_o),
  .op_size_o  (op_size_o),
  .pf_flush_o (pf_flush_o),
  .fifo_cnt   (fifo_cnt),
  .eng_busy   (eng_busy),
  .own_v      (own_v),
  .own_id     (own_id),
  .sync_pend  (sync_pend)
);

// File: tb/tb_cmq_frontend.sv
`timescale 1ns/1ps
module tb_cmq_frontend;
  localparam int NCPU = 4, DEPTH = 4, LAT = 40, CPU_W = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [CPU_W-1:0] req_cpu = 0;
  logic req_ready, op_start, op_all, pf_flush;
  logic [31:0] req_rdata, op_addr, op_size;
  logic [CPU_W-1:0] op_cpu;
  logic [3:0] op_code;

  always #2.5 clk = ~clk;

  cmq_frontend #(.NCPU(NCPU), .DEPTH(DEPTH), .LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_cpu_i(req_cpu), .req_rdata_o(req_rdata), .op_start_o(op_start),
    .op_cpu_o(op_cpu), .op_code_o(op_code), .op_all_o(op_all),
    .op_addr_o(op_addr), .op_size_o(op_size), .pf_flush_o(pf_flush));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // start monitor
  int mon_n = 0;
  int mon_cyc [64];
  logic [3:0] mon_code [64];
  logic mon_all [64];
  logic [31:0] mon_addr [64], mon_size [64];
  logic [CPU_W-1:0] mon_cpu [64];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (op_start && mon_n < 64) begin
    mon_cyc[mon_n] = cyc; mon_code[mon_n] = op_code; mon_all[mon_n] = op_all;
    mon_addr[mon_n] = op_addr; mon_size[mon_n] = op_size; mon_cpu[mon_n] = op_cpu;
    mon_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input int cpu, input bit wr, input logic [11:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output int stall);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_cpu = CPU_W'(cpu);
    #1; stall = 0;
    while (!req_ready) begin @(negedge clk); #1; stall++; end
    rd = req_rdata;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; int s;
    acc(cpu, 1, a, d, r, s);
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] r);
    int s;
    acc(cpu, 0, a, 0, r, s);
  endtask

  task automatic submit(input int cpu, input int code, input bit all, input bit ntf,
                        input logic [31:0] a, input logic [31:0] sz, output logic [31:0] rs);
    wr(cpu, 12'h248, 32'(code) | (ntf ? 32'h8000 : 0) | (all ? 32'h20000 : 0));
    wr(cpu, 12'h24C, a);
    wr(cpu, 12'h250, sz);
    rd(cpu, 12'h25C, rs);
  endtask

  task automatic wait_q(input int cpu, input logic [31:0] exp, input string req);
    logic [31:0] r;
    for (int i = 0; i < 400; i++) begin
      rd(cpu, 12'h260, r);
      if (r == exp) break;
    end
    chk(r == exp, req, r, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int c = 0; c < NCPU; c++)
      for (int i = 0; i < 400; i++) begin
        rd(c, 12'h260, r);
        if (r[0] == 1'b0) break;
      end
  endtask

  // watchdog
  always @(posedge clk) if (cyc > 150000 && !finished) begin
    finished = 1; n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, rs, ea, es;
    int s, exp_n, base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    #1 chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    for (int c = 0; c < NCPU; c++) begin
      rd(c, 12'h260, r); chk(r == 0, "R1 qstat", r, 0);
      rd(c, 12'h25C, r); chk(r == 0, "R1 rstat", r, 0);
    end
    rd(0, 12'h244, r); chk(r == 0, "R1 prim", r, 0);

    // R2 R6 R7 sweep over CPU, operation and scope
    exp_n = 0;
    for (int c = 0; c < NCPU; c++)
      for (int op = 0; op < 3; op++)
        for (int al = 0; al < 2; al++) begin
          bit ntf;
          ntf = (op != 1);
          ea = 32'h0010_0000 + 32'(c << 12) + 32'(op << 8);
          es = 32'h40 * 32'(op + 1);
          submit(c, op, al[0], ntf, ea, es, rs);
          chk(rs == 0, "R4 accepted", rs, 0);
          rd(c, 12'h260, r); chk(r[0] == 1'b1, "R7 busy", r, 1);
          rd((c + 1) % NCPU, 12'h260, r); chk(r == 0, "R7 isolation", r, 0);
          wait_q(c, ntf ? 32'h4 : 32'h0, "R7 done/idle");
          chk(mon_n == exp_n + 1, "R5 one start", mon_n, exp_n + 1);
          chk(mon_code[exp_n] == 4'(op), "R2 code", mon_code[exp_n], op);
          chk(mon_cpu[exp_n] == CPU_W'(c), "R2 cpu", mon_cpu[exp_n], c);
          chk(mon_all[exp_n] == al[0], "R2 scope", mon_all[exp_n], al);
          chk(mon_addr[exp_n] == (al ? 0 : ea), "R6 addr", mon_addr[exp_n], al ? 0 : ea);
          chk(mon_size[exp_n] == (al ? 0 : es), "R6 size", mon_size[exp_n], al ? 0 : es);
          exp_n++;
          wr(c, 12'h260, 32'h4);
          rd(c, 12'h260, r); chk(r == 0, "R7 clear done", r, 0);
        end

    // R3 lock conflict
    wr(0, 12'h248, 32'h2);
    wr(1, 12'h248, 32'h20000);
    wr(1, 12'h24C, 32'hDEAD0000);
    wr(0, 12'h24C, 32'h1000);
    wr(0, 12'h250, 32'h40);
    rd(1, 12'h25C, r); chk(r == 1, "R3 refused", r, 1);
    rd(1, 12'h25C, r); chk(r == 0, "R4 flag cleared by read", r, 0);
    rd(0, 12'h25C, r); chk(r == 0, "R3 owner commit", r, 0);
    wait_q(0, 0, "R3 owner done");
    chk(mon_n == exp_n + 1, "R3 one start", mon_n, exp_n + 1);
    chk(mon_code[exp_n] == 2 && mon_all[exp_n] == 0, "R3 mode kept", {mon_code[exp_n], 3'b0, mon_all[exp_n]}, 32'h20);
    chk(mon_addr[exp_n] == 32'h1000, "R3 addr kept", mon_addr[exp_n], 32'h1000);
    chk(mon_size[exp_n] == 32'h40, "R3 size kept", mon_size[exp_n], 32'h40);
    exp_n++;
    rd(1, 12'h260, r); chk(r == 2, "R7 err bit", r, 2);
    wr(1, 12'h260, 32'h2);
    rd(1, 12'h260, r); chk(r == 0, "R7 clear err", r, 0);
    wr(3, 12'h24C, 32'h5);
    rd(3, 12'h25C, r); chk(r == 1, "R3 no owner refusal", r, 1);
    wr(3, 12'h260, 32'h2);
    submit(1, 0, 0, 0, 32'h2000, 32'h80, rs); chk(rs == 0, "R3 released", rs, 0);
    wait_q(1, 0, "R3 second idle"); exp_n++;

    // R4 R5 queue full and ordering
    base = exp_n;
    for (int k = 0; k < 6; k++) begin
      submit(2, 1, 0, 0, 32'h3000 + 32'(k << 6), 32'h40, rs);
      chk(rs == ((k == 5) ? 32'h2 : 32'h0), "R4 full flag", rs, (k == 5) ? 2 : 0);
    end
    rd(2, 12'h260, r); chk(r[1] == 1'b1, "R7 err on full", r, 3);
    wait_q(2, 32'h2, "R5 drain");
    chk(mon_n == base + 5, "R5 count", mon_n, base + 5);
    for (int k = 0; k < 5; k++)
      chk(mon_addr[base + k] == 32'h3000 + 32'(k << 6), "R5 order", mon_addr[base + k], 32'h3000 + 32'(k << 6));
    for (int k = 1; k < 5; k++)
      chk(mon_cyc[base + k] - mon_cyc[base + k - 1] == LAT + 1, "R5 spacing",
          mon_cyc[base + k] - mon_cyc[base + k - 1], LAT + 1);
    wr(2, 12'h260, 32'h6);
    exp_n = mon_n;

    // R8 sync drain
    submit(3, 2, 0, 0, 32'h4000, 32'h40, rs);
    wr(3, 12'h244, 32'h8);
    acc(3, 0, 12'h244, 0, r, s);
    chk(r == 32'h8, "R8 sync value", r, 8);
    chk(s > 0, "R8 stalled", s, 1);
    rd(3, 12'h260, r); chk(r == 0, "R8 drained", r, 0);
    acc(3, 0, 12'h244, 0, r, s);
    chk(r == 0 && s == 0, "R8 disarmed", r, 0);

    // R9 prefetch flush
    wr(0, 12'h244, 32'h9);
    chk(pf_flush == 1'b1, "R9 pulse", pf_flush, 1);
    @(posedge clk); #1 chk(pf_flush == 1'b0, "R9 one cycle", pf_flush, 0);
    wr(0, 12'h244, 32'h5);
    chk(pf_flush == 1'b0, "R9 other code", pf_flush, 0);
    rd(0, 12'h244, r); chk(r == 0, "R9 not armed", r, 0);

    // R10 unmapped offsets
    wr(0, 12'h100, 32'hFFFF_FFFF);
    rd(0, 12'h100, r); chk(r == 0, "R10 read", r, 0);
    wr(0, 12'h248, 32'h1);
    wr(0, 12'h24C, 32'h5000);
    wr(0, 12'h250, 32'h40);
    wr(0, 12'h254, 32'hFFFF_FFFF);
    rd(0, 12'h25C, rs); chk(rs == 0, "R10 commit", rs, 0);
    wait_idle();
    chk(mon_size[mon_n - 1] == 32'h40 && mon_addr[mon_n - 1] == 32'h5000, "R10 staging intact",
        mon_size[mon_n - 1], 32'h40);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule